// File: doc/BRIEF.md
# PWM Output Action Qualifier with Held Software Override

This block turns the event strobes of a PWM time base into two output levels, one per channel. The strobes are counter-at-zero, counter-at-period, compare-A match while counting up, and compare-B match while counting up. Each channel owns an action word that gives a two-bit action for every event: leave the level alone, drive it low, drive it high, or invert it. Events take effect only on cycles where the count tick enable is high, so the block runs at the time-base rate while sitting in the system clock domain.

Software can also hold either output low or high through an override word. Software writes a shadow copy of the override. A reload mode picks the moment at which the shadow copy becomes active: at the zero event, at the period event, at either of them, or on every tick. While an override is active it wins over every event action of that channel. When it is released, the event actions continue from whatever level the output holds at that time. A driver makes a normal-polarity waveform by going high at zero and low at the compare match. It inverts the waveform by swapping those two actions. For a duty cycle above the period it leaves the compare action empty.

Top module: `pwm_action_qual`

## Requirements
- R1: An active-low asynchronous reset drives both outputs low and clears both action words, the shadow and active override and the reload mode to 0. After reset, events change nothing.
- R2: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_sel`: 0 selects the channel A action word, 1 selects the channel B action word, 2 selects the override shadow and 3 selects the reload mode. The stored value is used from the next cycle. A write changes no output until a tick applies it.
- R3: Action codes are 00 for no change, 01 for low, 10 for high and 11 for invert. They are applied to the output register on a cycle with `tick_en` high.
- R4: In both action words the zero event uses bits [1:0], the period event bits [3:2], the compare-A event bits [5:4] and the compare-B event bits [9:8]. Each channel decodes all four fields of its own word, so either waveform polarity can be built.
- R5: With `tick_en` low, both outputs hold their level whatever the event inputs do.
- R6: When several events with a non-zero action arrive on one tick, only the highest ranked one acts. The order is period, then zero, then compare-B, then compare-A. An event whose action is 00 does not block a lower ranked event.
- R7: In the override word, bits [1:0] belong to channel A and bits [3:2] to channel B. Code 01 holds the output low, 10 holds it high, and 00 and 11 leave it free. An active hold overrides all event actions of its channel on every tick.
- R8: The reload mode is bits [7:6] of its register, and every other bit of that register is ignored. Mode 00 copies the shadow to the active override on a tick with the zero event, 01 on a tick with the period event, 10 on a tick with either, and 11 on every tick. The copied value controls the output from that same tick.
- R9: When a hold is released, the next event action starts from the level the hold left on the output.
- R10: With the compare action at 00, a channel follows only its zero and period actions. A zero-high word with nothing else keeps the output high through the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count tick enable; events and reloads act only when high |
| evt_zero | input | 1 | Time-base counter at zero |
| evt_period | input | 1 | Time-base counter at period |
| evt_cmpa_up | input | 1 | Compare-A match while counting up |
| evt_cmpb_up | input | 1 | Compare-B match while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 action A, 1 action B, 2 override shadow, 3 reload mode) |
| wr_data | input | CTRL_W | Register write data |
| pwm_a | output | 1 | Channel A output level |
| pwm_b | output | 1 | Channel B output level |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that the event strobes have meaning only when `tick_en` is high, so a property about actions uses a tick cycle as its antecedent. The bench drives all inputs on the falling edge, so they are stable around each rising edge. For most phases it derives the event strobes from its own up-counter, which makes zero, period and compare matches fall where a real time base would put them. The priority and random phases drive every combination of strobes together, to reach the collisions that R6 covers.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } aq_act_e;

  typedef enum logic [1:0] {
    LD_ZERO   = 2'b00,
    LD_PERIOD = 2'b01,
    LD_EITHER = 2'b10,
    LD_NOW    = 2'b11
  } aq_ld_e;

  // event vector bit indices
  localparam int EV_ZERO  = 0;
  localparam int EV_PRD   = 1;
  localparam int EV_CMPA  = 2;
  localparam int EV_CMPB  = 3;
  localparam int EV_CNT   = 4;
  localparam int ACT_BITS = 2;
  localparam int FRC_BITS = 2;
  localparam int MODE_LSB = 6;

  // low bit of an event's field inside an action word
  function automatic int field_lsb(input int ev);
    case (ev)
      EV_ZERO: return 0;
      EV_PRD:  return 2;
      EV_CMPA: return 4;
      default: return 8;
    endcase
  endfunction

  // event index at a given rank, rank 0 wins
  function automatic int prio_event(input int rank);
    case (rank)
      0:       return EV_PRD;
      1:       return EV_ZERO;
      2:       return EV_CMPB;
      default: return EV_CMPA;
    endcase
  endfunction

  function automatic logic apply_act(input aq_act_e act, input logic cur);
    case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  // returns {hold_valid, hold_level}
  function automatic logic [1:0] force_decode(input logic [FRC_BITS-1:0] code);
    case (code)
      2'b01:   return 2'b10;
      2'b10:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic reload_due(input aq_ld_e mode, input logic z, input logic p);
    case (mode)
      LD_ZERO:   return z;
      LD_PERIOD: return p;
      LD_EITHER: return z | p;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int CTRL_W = 16,
  parameter int NUM_CH = 2,
  parameter int ACT_W  = 10,
  parameter int FRC_W  = 4,
  localparam int SEL_W = $clog2(NUM_CH + 2)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [CTRL_W-1:0]              wr_data,
  output logic [NUM_CH-1:0][ACT_W-1:0]   act_word,
  output logic [FRC_W-1:0]               frc_shadow,
  output aq_ld_e                         ld_mode
);
  localparam int SEL_FRC  = NUM_CH;
  localparam int SEL_MODE = NUM_CH + 1;

  logic unused_wr;
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_word   <= '0;
      frc_shadow <= '0;
      ld_mode    <= LD_ZERO;
    end else if (wr_en) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_sel == SEL_W'(c)) act_word[c] <= wr_data[ACT_W-1:0];
      end
      if (wr_sel == SEL_W'(SEL_FRC))  frc_shadow <= wr_data[FRC_W-1:0];
      if (wr_sel == SEL_W'(SEL_MODE)) ld_mode    <= aq_ld_e'(wr_data[MODE_LSB +: 2]);
    end
  end

endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
  import pwm_aq_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int FRC_W = FRC_BITS * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic [FRC_W-1:0]  frc_shadow,
  input  aq_ld_e            ld_mode,
  output logic [FRC_W-1:0]  frc_active,
  output logic [NUM_CH-1:0] frc_vld,
  output logic [NUM_CH-1:0] frc_lvl
);
  logic             load_now;
  logic [FRC_W-1:0] frc_next;

  assign load_now = tick_en & reload_due(ld_mode, evt_zero, evt_period);
  // a freshly loaded value governs the output on the same tick
  assign frc_next = load_now ? frc_shadow : frc_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frc_active <= '0;
    else if (load_now) frc_active <= frc_shadow;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    logic [1:0] dec;
    assign dec        = force_decode(frc_next[g*FRC_BITS +: FRC_BITS]);
    assign frc_vld[g] = dec[1];
    assign frc_lvl[g] = dec[0];
  end

endmodule

// File: rtl/pwm_aq_select.sv
module pwm_aq_select
  import pwm_aq_pkg::*;
#(
  parameter int ACT_W = 10
) (
  input  logic [ACT_W-1:0]  act_word,
  input  logic [EV_CNT-1:0] evt_vec,
  output aq_act_e           act_sel,
  output logic [EV_CNT-1:0] pick
);
  localparam int GAP_LO = field_lsb(EV_CMPA) + ACT_BITS;
  localparam int GAP_HI = field_lsb(EV_CMPB) - 1;

  logic unused_gap;
  assign unused_gap = ^act_word[GAP_HI:GAP_LO];

  always_comb begin
    logic            found;
    logic [1:0]      code;
    int              ev;
    found   = 1'b0;
    pick    = '0;
    act_sel = ACT_NONE;
    for (int rank = 0; rank < EV_CNT; rank++) begin
      ev   = prio_event(rank);
      code = act_word[field_lsb(ev) +: ACT_BITS];
      if (!found && evt_vec[ev] && code != 2'b00) begin
        found    = 1'b1;
        pick[ev] = 1'b1;
        act_sel  = aq_act_e'(code);
      end
    end
  end

endmodule

// File: rtl/pwm_aq_out.sv
module pwm_aq_out
  import pwm_aq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_en,
  input  logic    frc_vld,
  input  logic    frc_lvl,
  input  aq_act_e act_sel,
  output logic    pwm
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pwm <= 1'b0;
    else if (tick_en) pwm <= frc_vld ? frc_lvl : apply_act(act_sel, pwm);
  end
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              evt_cmpa_up,
  input  logic              evt_cmpb_up,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int NUM_CH = 2;
  localparam int FRC_W  = FRC_BITS * NUM_CH;
  localparam int ACT_W  = field_lsb(EV_CMPB) + ACT_BITS;

  logic [NUM_CH-1:0][ACT_W-1:0]  act_word;
  logic [FRC_W-1:0]              frc_shadow;
  logic [FRC_W-1:0]              frc_active;
  aq_ld_e                        ld_mode;
  logic [NUM_CH-1:0]             frc_vld;
  logic [NUM_CH-1:0]             frc_lvl;
  logic [NUM_CH-1:0]             pwm_vec;
  logic [EV_CNT-1:0]             evt_vec;
  logic [NUM_CH-1:0][EV_CNT-1:0] pick_vec;
  aq_act_e                       act_vec [NUM_CH];

  // named views for the checker
  logic [EV_CNT-1:0] pick_a, pick_b;
  aq_act_e           act_a, act_b;

  always_comb begin
    evt_vec          = '0;
    evt_vec[EV_ZERO] = evt_zero;
    evt_vec[EV_PRD]  = evt_period;
    evt_vec[EV_CMPA] = evt_cmpa_up;
    evt_vec[EV_CMPB] = evt_cmpb_up;
  end

  pwm_aq_regs #(
    .CTRL_W(CTRL_W), .NUM_CH(NUM_CH), .ACT_W(ACT_W), .FRC_W(FRC_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .act_word(act_word), .frc_shadow(frc_shadow), .ld_mode(ld_mode)
  );

  pwm_aq_force #(.NUM_CH(NUM_CH)) force_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .evt_zero(evt_zero), .evt_period(evt_period),
    .frc_shadow(frc_shadow), .ld_mode(ld_mode),
    .frc_active(frc_active), .frc_vld(frc_vld), .frc_lvl(frc_lvl)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_aq_select #(.ACT_W(ACT_W)) sel_i (
      .act_word(act_word[g]), .evt_vec(evt_vec),
      .act_sel(act_vec[g]), .pick(pick_vec[g])
    );
    pwm_aq_out out_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .frc_vld(frc_vld[g]), .frc_lvl(frc_lvl[g]),
      .act_sel(act_vec[g]), .pwm(pwm_vec[g])
    );
  end

  assign pick_a = pick_vec[0];
  assign pick_b = pick_vec[1];
  assign act_a  = act_vec[0];
  assign act_b  = act_vec[1];
  assign pwm_a  = pwm_vec[0];
  assign pwm_b  = pwm_vec[1];

endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       pwm_a,
  input logic       pwm_b,
  input logic [1:0] frc_vld,
  input logic [1:0] frc_lvl,
  input logic [3:0] pick_a,
  input logic [3:0] pick_b,
  input logic [1:0] act_a,
  input logic [1:0] ld_mode,
  input logic [3:0] frc_shadow,
  input logic [3:0] frc_active
);
  // R5
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(pwm_a));
  // R5
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(pwm_b));
  // R7
  force_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && frc_vld[0] |=> pwm_a == $past(frc_lvl[0]));
  // R7
  force_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && frc_vld[1] |=> pwm_b == $past(frc_lvl[1]));
  // R6
  pick_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_a));
  // R6
  pick_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_b));
  // R8
  load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && ld_mode == 2'b11 |=> frc_active == $past(frc_shadow));
  // R3
  toggle_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !frc_vld[0] && act_a == 2'b11 |=> pwm_a != $past(pwm_a));
endmodule

bind pwm_action_qual pwm_aq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
  .pwm_a(pwm_a), .pwm_b(pwm_b),
  .frc_vld(frc_vld), .frc_lvl(frc_lvl),
  .pick_a(pick_a), .pick_b(pick_b), .act_a(act_a),
  .ld_mode(ld_mode), .frc_shadow(frc_shadow), .frc_active(frc_active)
);

// File: tb/pwm_action_qual_tb_top.sv
module pwm_action_qual_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        evt_zero = 1'b0, evt_period = 1'b0, evt_cmpa_up = 1'b0, evt_cmpb_up = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  wire         pwm_a, pwm_b;

  always #(CLK_P/2) clk = ~clk;

  pwm_action_qual dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .evt_zero(evt_zero), .evt_period(evt_period),
    .evt_cmpa_up(evt_cmpa_up), .evt_cmpb_up(evt_cmpb_up),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  int    vectors = 0;
  int    miscmp  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [15:0] m_wa = 0, m_wb = 0, m_sh = 0;
  logic [1:0]  m_md = 0;
  logic [3:0]  m_ac = 0;
  logic        m_a = 0, m_b = 0, m_load = 0;

  function automatic logic chan_next(input logic [15:0] w, input logic [1:0] f,
                                     input logic z, input logic p, input logic ca,
                                     input logic cb, input logic cur);
    logic [1:0] c;
    if (f == 2'b01) return 1'b0;
    if (f == 2'b10) return 1'b1;
    c = 2'b00;
    if (p && w[3:2] != 0)       c = w[3:2];
    else if (z && w[1:0] != 0)  c = w[1:0];
    else if (cb && w[9:8] != 0) c = w[9:8];
    else if (ca && w[5:4] != 0) c = w[5:4];
    case (c)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wa = 0; m_wb = 0; m_sh = 0; m_md = 0; m_ac = 0; m_a = 0; m_b = 0;
    end else begin
      if (tick_en) begin
        case (m_md)
          2'd0:    m_load = evt_zero;
          2'd1:    m_load = evt_period;
          2'd2:    m_load = evt_zero || evt_period;
          default: m_load = 1'b1;
        endcase
        if (m_load) m_ac = m_sh[3:0];
        m_a = chan_next(m_wa, m_ac[1:0], evt_zero, evt_period, evt_cmpa_up, evt_cmpb_up, m_a);
        m_b = chan_next(m_wb, m_ac[3:2], evt_zero, evt_period, evt_cmpa_up, evt_cmpb_up, m_b);
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0:    m_wa = wr_data;
          2'd1:    m_wb = wr_data;
          2'd2:    m_sh = wr_data;
          default: m_md = wr_data[7:6];
        endcase
      end
    end
  end

  task automatic check();
    vectors++;
    if (pwm_a !== m_a || pwm_b !== m_b) begin
      miscmp++;
      $display("FAIL %s: {pwm_a,pwm_b} actual %b%b expected %b%b at %0t",
               cur_req, pwm_a, pwm_b, m_a, m_b, $time);
    end
  endtask

  task automatic step(input logic t, input logic z, input logic p, input logic ca, input logic cb);
    wr_en = 1'b0; tick_en = t;
    evt_zero = z; evt_period = p; evt_cmpa_up = ca; evt_cmpb_up = cb;
    @(negedge clk);
    check();
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    tick_en = 1'b0; evt_zero = 0; evt_period = 0; evt_cmpa_up = 0; evt_cmpb_up = 0;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check();
  endtask

  // up-counting time base: 0..prd, compare matches at ca / cb (-1 never)
  task automatic run(input int prd, input int ca, input int cb, input int periods);
    for (int n = 0; n < periods; n++)
      for (int c = 0; c <= prd; c++)
        step(1'b1, c == 0, c == prd, c == ca, c == cb);
  endtask

  initial begin
    // R1: reset state and cleared action words
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check();
    rst_n = 1'b1;
    repeat (3) step(1, 1, 1, 1, 1);

    // R2: writes alone do not move the outputs
    cur_req = "R2";
    wr(2'd0, 16'h0012);
    wr(2'd1, 16'h0102);
    step(0, 1, 0, 0, 0);

    // R3: normal polarity, high at zero, low at compare
    cur_req = "R3";
    run(9, 3, 6, 3);

    // R4: inverted polarity via swapped fields
    cur_req = "R4";
    wr(2'd0, 16'h0021);
    wr(2'd1, 16'h0201);
    run(7, 2, 5, 2);

    // R5: no tick, events ignored
    cur_req = "R5";
    repeat (6) step(0, 1, 1, 1, 1);

    // R10: compare action none gives a full level
    cur_req = "R10";
    wr(2'd0, 16'h0002);
    wr(2'd1, 16'h0006);
    run(5, -1, -1, 2);
    run(5, 2, 2, 2);

    // R3: invert action on zero and on period
    cur_req = "R3";
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'h000C);
    run(4, 1, 3, 3);

    // R6: every event collision
    cur_req = "R6";
    wr(2'd0, 16'h0236);
    wr(2'd1, 16'h0321);
    for (int r = 0; r < 2; r++)
      for (int v = 0; v < 16; v++)
        step(1, v[0], v[1], v[2], v[3]);

    // R7: immediate hold low/high, codes 11 and 00 release
    cur_req = "R7";
    wr(2'd0, 16'h0012);
    wr(2'd1, 16'h0102);
    wr(2'd3, 16'h00C0);
    wr(2'd2, 16'h0009);
    run(4, 1, 2, 2);
    wr(2'd2, 16'h000F);
    run(4, 1, 2, 1);
    wr(2'd2, 16'h0006);
    run(4, 1, 2, 1);
    wr(2'd2, 16'h0000);
    run(4, 1, 2, 1);

    // R8: reload points, other bits of the mode word ignored
    cur_req = "R8";
    wr(2'd3, 16'hFF3F);
    wr(2'd2, 16'h0009);
    run(6, 2, 4, 2);
    wr(2'd3, 16'h0040);
    step(1, 0, 0, 1, 0);
    wr(2'd2, 16'h0006);
    run(6, 2, 4, 2);
    wr(2'd3, 16'h0080);
    wr(2'd2, 16'h0000);
    run(6, 2, 4, 1);
    wr(2'd2, 16'h0009);
    run(6, 2, 4, 1);
    wr(2'd3, 16'h00C0);
    wr(2'd2, 16'h0006);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);

    // R9: release resumes inverting from the held level
    cur_req = "R9";
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'h0003);
    wr(2'd2, 16'h0009);
    run(3, 9, 9, 1);
    wr(2'd2, 16'h0000);
    run(3, 9, 9, 3);

    // R6: random mix of writes and strobes
    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 8 == 0) wr(2'($urandom), 16'($urandom));
      else step(($urandom % 4) != 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL %s: watchdog expired, actual running expected finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

endmodule